// File: doc/BRIEF.md
# Per-Pin Interrupt Trigger Style Unit

This block turns each of sixteen input pins into an interrupt source. Every pin first crosses into the clock domain through a two-flop synchroniser. The synchronised value and the value one cycle older are then tested against a trigger style chosen for that pin. When the condition is met, the pin's pending flag is set. The flag drives that pin's interrupt request line directly.

Software programs the block through a small register bus with address, write data, write enable and read data. Two style words hold a 3-bit trigger code per pin, one word for each half of the pins. A pending word shows the flags, and writing 1 to a bit of it clears that flag. To change a pin's style, software rewrites the pin's field and then clears its pending bit.

A level-style flag comes back on the very next cycle if its condition still holds. A clear only succeeds once the level has gone away.

Top module: `pin_irq_top`

## Requirements
- R1: After reset every style field and every pending flag is 0, and all interrupt outputs are low while the pins are low.
- R2: Bus address 0 holds the style fields of pins 0..7 and address 1 those of pins 8..15. The field of a pin sits at bit offset (pin index within its half) x 3. Bits 31..24 of both words read as 0, and the fields read back as written.
- R3: Style code 0 (active high) sets a pin's flag while its synchronised input is 1. A pin change made before clock edge k is visible on the interrupt output after edge k+2 and not before.
- R4: Style code 1 (active low) sets the flag while the synchronised input is 0.
- R5: Style code 2 (rising) sets the flag on a 0-to-1 transition. The flag stays set after the pin returns low.
- R6: Style code 3 (falling) sets the flag on a 1-to-0 transition.
- R7: Style code 4 (transitional) sets the flag on either transition.
- R8: Style codes 5, 6 and 7 never set the flag.
- R9: Writing address 2 clears each flag whose write-data bit (bit n for pin n) is 1. Write-data bits that are 0 leave their flags unchanged.
- R10: A clear of a level-style flag has no effect while the level condition still holds. The flag stays set after the level goes away, until it is cleared again.
- R11: Each interrupt output equals its pending flag, and reading address 2 returns the flags in bits 15..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 2 | Register address |
| busWdata | input | 32 | Register write data |
| busWe | input | 1 | Write enable |
| busRdata | output | 32 | Register read data (combinational) |
| pinIn | input | 16 | Asynchronous pin inputs |
| irqOut | output | 16 | Per-pin interrupt requests |

## Verification
The hardest case to reach is a clear that lands while a level condition still holds. The write and the re-latch fall on the same clock edge, and only the re-latch must take effect. Edge triggers are also hard, because they sample the synchroniser pair only during the single cycle in which the two differ.

The stimulus works through a table. For each row it programs one style into all pins and applies a first pin pattern. It waits for the synchroniser to settle, then clears every flag, so that only level conditions survive the clear. It then applies a second pattern. The expected vector therefore combines the re-latched levels with the edges between the two patterns. Directed sequences cover the exact three-edge latency, a style mix across pins, and a clear first retried while a level holds and then after it is gone.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  parameter int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_STYLE_LO = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_STYLE_HI = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_PENDING  = 2'd2;

  localparam logic [2:0] STY_HIGH = 3'd0;
  localparam logic [2:0] STY_LOW  = 3'd1;
  localparam logic [2:0] STY_RISE = 3'd2;
  localparam logic [2:0] STY_FALL = 3'd3;
  localparam logic [2:0] STY_BOTH = 3'd4;

  typedef struct packed {
    logic styleLoWr;
    logic styleHiWr;
    logic pendClr;
  } strobe_t;
endpackage

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
  import pin_irq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_PINS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] styleLoWord,
  input  logic [DATA_W-1:0] styleHiWord,
  input  logic [NUM_PINS-1:0] pendWord,
  output strobe_t           strobes,
  output logic [DATA_W-1:0] busRdata
);
  always_comb begin
    strobes = '0;
    if (busWe) begin
      unique case (busAddr)
        ADDR_STYLE_LO: strobes.styleLoWr = 1'b1;
        ADDR_STYLE_HI: strobes.styleHiWr = 1'b1;
        ADDR_PENDING:  strobes.pendClr   = 1'b1;
        default:       strobes = '0;
      endcase
    end
  end

  always_comb begin
    unique case (busAddr)
      ADDR_STYLE_LO: busRdata = styleLoWord;
      ADDR_STYLE_HI: busRdata = styleHiWord;
      ADDR_PENDING:  busRdata = DATA_W'(pendWord);
      default:       busRdata = '0;
    endcase
  end

  // R2
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes));

  // R9
  strobe_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busWe |-> (strobes == '0));
endmodule

// File: rtl/pin_irq_datapath.sv
module pin_irq_datapath
  import pin_irq_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int DATA_W = 32,
  parameter int STYLE_W = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strobes,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [DATA_W-1:0]   styleLoWord,
  output logic [DATA_W-1:0]   styleHiWord,
  output logic [NUM_PINS-1:0] pendWord
);
  localparam int GROUP = NUM_PINS / 2;

  logic [NUM_PINS-1:0] syncStage1, syncVal, prevVal, condHit, clrMask, pendReg;
  logic [STYLE_W-1:0]  styleReg [NUM_PINS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncStage1 <= '0;
      syncVal    <= '0;
      prevVal    <= '0;
    end else begin
      syncStage1 <= pinIn;
      syncVal    <= syncStage1;
      prevVal    <= syncVal;
    end
  end

  for (genvar g = 0; g < GROUP; g++) begin : gStyle
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        styleReg[g]       <= '0;
        styleReg[g+GROUP] <= '0;
      end else begin
        if (strobes.styleLoWr) styleReg[g]       <= wrData[g*STYLE_W +: STYLE_W];
        if (strobes.styleHiWr) styleReg[g+GROUP] <= wrData[g*STYLE_W +: STYLE_W];
      end
    end
  end

  always_comb begin
    styleLoWord = '0;
    styleHiWord = '0;
    for (int g = 0; g < GROUP; g++) begin
      styleLoWord[g*STYLE_W +: STYLE_W] = styleReg[g];
      styleHiWord[g*STYLE_W +: STYLE_W] = styleReg[g+GROUP];
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : gCond
    always_comb begin
      unique case (styleReg[p])
        STY_HIGH: condHit[p] = syncVal[p];
        STY_LOW:  condHit[p] = !syncVal[p];
        STY_RISE: condHit[p] = syncVal[p] && !prevVal[p];
        STY_FALL: condHit[p] = !syncVal[p] && prevVal[p];
        STY_BOTH: condHit[p] = syncVal[p] ^ prevVal[p];
        default:  condHit[p] = 1'b0;
      endcase
    end
  end

  assign clrMask = strobes.pendClr ? wrData[NUM_PINS-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendReg <= '0;
    else       pendReg <= (pendReg & ~clrMask) | condHit;
  end

  assign pendWord = pendReg;

  for (genvar p = 0; p < NUM_PINS; p++) begin : gChk
    // R3
    level_high_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
      (styleReg[p] == STY_HIGH && syncVal[p]) |=> pendReg[p]);
    // R5
    rise_needs_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
      ($rose(pendReg[p]) && $past(styleReg[p]) == STY_RISE) |-> $past(syncVal[p] && !prevVal[p]));
    // R8
    disabled_code_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(pendReg[p]) |-> ($past(styleReg[p]) <= STY_BOTH));
    // R9
    clear_only_by_write_chk: assert property (@(posedge clk) disable iff (!rstN)
      $fell(pendReg[p]) |-> $past(strobes.pendClr && wrData[p]));
  end
endmodule

// File: rtl/pin_irq_top.sv
module pin_irq_top
  import pin_irq_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int DATA_W = 32,
  parameter int STYLE_W = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWdata,
  input  logic                busWe,
  output logic [DATA_W-1:0]   busRdata,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] irqOut
);
  strobe_t             strobes;
  logic [DATA_W-1:0]   styleLoWord, styleHiWord;
  logic [NUM_PINS-1:0] pendWord;

  pin_irq_ctrl #(.DATA_W(DATA_W), .NUM_PINS(NUM_PINS)) i_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .styleLoWord(styleLoWord), .styleHiWord(styleHiWord), .pendWord(pendWord),
    .strobes(strobes), .busRdata(busRdata)
  );

  pin_irq_datapath #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .STYLE_W(STYLE_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(busWdata), .pinIn(pinIn),
    .styleLoWord(styleLoWord), .styleHiWord(styleHiWord), .pendWord(pendWord)
  );

  // R11
  assign irqOut = pendWord;
endmodule

// File: tb/test_pin_irq_top.sv
module test_pin_irq_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic        busWe = 1'b0;
  logic [31:0] busRdata;
  logic [15:0] pinIn = '0;
  logic [15:0] irqOut;
  int nVec = 0;
  int nBad = 0;

  pin_irq_top i_pin_irq_top (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata), .busWe(busWe),
    .busRdata(busRdata), .pinIn(pinIn), .irqOut(irqOut)
  );

  always #2 clk = ~clk;

  // {style code, first pattern, second pattern, expected irq}
  localparam logic [50:0] VECS [12] = '{
    {3'd0, 16'h0F0F, 16'h3355, 16'h3F5F},  // R3
    {3'd1, 16'h0F0F, 16'h3355, 16'hFCFA},  // R4
    {3'd2, 16'h0F0F, 16'h3355, 16'h3050},  // R5
    {3'd3, 16'h0F0F, 16'h3355, 16'h0C0A},  // R6
    {3'd4, 16'h0F0F, 16'h3355, 16'h3C5A},  // R7
    {3'd5, 16'h0F0F, 16'h3355, 16'h0000},  // R8
    {3'd6, 16'h0F0F, 16'h3355, 16'h0000},  // R8
    {3'd7, 16'h0F0F, 16'h3355, 16'h0000},  // R8
    {3'd2, 16'h0000, 16'hFFFF, 16'hFFFF},  // R5
    {3'd2, 16'hFFFF, 16'h0000, 16'h0000},  // R5
    {3'd3, 16'h0000, 16'hFFFF, 16'h0000},  // R6
    {3'd3, 16'hFFFF, 16'h0000, 16'hFFFF}   // R6
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0; busWdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    busAddr = a;
    #1 d = busRdata;
  endtask

  function automatic logic [31:0] allStyle(input logic [2:0] c);
    return {8'h00, {8{c}}};
  endfunction

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    nBad++;
    $display("FAIL watchdog actual=%0d expected=<100000", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 irq", {16'h0, irqOut}, 32'h0);
    rd(2'd0, r); check("R1 styleLo", r, 32'h0);
    rd(2'd1, r); check("R1 styleHi", r, 32'h0);
    rd(2'd2, r); check("R1 pending", r, 32'h0);
    @(negedge clk);

    // R2 readback and field masking
    wr(2'd0, 32'hFFFAC688); rd(2'd0, r); check("R2 lo readback", r, 32'h00FAC688);
    @(negedge clk);
    wr(2'd1, 32'h12345678); rd(2'd1, r); check("R2 hi readback", r, 32'h00345678);
    @(negedge clk);

    // R2 layout: only pin 9 rising, others disabled
    wr(2'd0, 32'h00FFFFFF);
    wr(2'd1, 32'h00FFFFD7);
    repeat (4) @(negedge clk);
    wr(2'd2, 32'h0000FFFF);
    pinIn = 16'hFFFF;
    repeat (5) @(negedge clk);
    check("R2 pin9 field", {16'h0, irqOut}, 32'h00000200);
    pinIn = 16'h0000;
    repeat (5) @(negedge clk);

    // table walk
    for (int v = 0; v < 12; v++) begin
      wr(2'd0, allStyle(VECS[v][50:48]));
      wr(2'd1, allStyle(VECS[v][50:48]));
      pinIn = VECS[v][47:32];
      repeat (5) @(negedge clk);
      wr(2'd2, 32'h0000FFFF);
      pinIn = VECS[v][31:16];
      repeat (5) @(negedge clk);
      check($sformatf("R3-style table row %0d", v), {16'h0, irqOut}, {16'h0, VECS[v][15:0]});
      rd(2'd2, r);
      check("R11 pending read equals irq", r, {16'h0, VECS[v][15:0]});
      @(negedge clk);
    end

    // R3 latency: active high on all pins
    wr(2'd0, 32'h0); wr(2'd1, 32'h0);
    pinIn = 16'h0000;
    repeat (4) @(negedge clk);
    wr(2'd2, 32'h0000FFFF);
    @(negedge clk);
    pinIn = 16'h0001;
    repeat (2) @(negedge clk);
    check("R3 not before edge k+2", {16'h0, irqOut}, 32'h0);
    @(negedge clk);
    check("R3 at edge k+2", {16'h0, irqOut}, 32'h1);

    // R10 clear while level holds
    wr(2'd2, 32'h00000001);
    check("R10 clear blocked", {16'h0, irqOut}, 32'h1);
    pinIn = 16'h0000;
    repeat (4) @(negedge clk);
    check("R10 stays latched", {16'h0, irqOut}, 32'h1);
    // R9 zero bits have no effect
    wr(2'd2, 32'h0000FFFE);
    check("R9 zero write", {16'h0, irqOut}, 32'h1);
    wr(2'd2, 32'h00000001);
    check("R9 one write clears", {16'h0, irqOut}, 32'h0);

    // R4 latched low flags with a partial clear
    wr(2'd0, allStyle(3'd1)); wr(2'd1, allStyle(3'd1));
    pinIn = 16'hFFFF;
    repeat (4) @(negedge clk);
    wr(2'd2, 32'h0000FFFF);
    pinIn = 16'h00F0;
    repeat (5) @(negedge clk);
    pinIn = 16'hFFFF;
    repeat (4) @(negedge clk);
    wr(2'd2, 32'h0000000F);
    check("R4 partial clear", {16'h0, irqOut}, 32'h0000FF00);

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule